// File: doc/BRIEF.md
# Palette Framebuffer Control Register Decoder

This block is the software-facing register front end of a palette-based framebuffer controller. A 32-bit word bus with separate read and write strobes reaches it. Each access is decoded to one of four destinations: the 256-entry color lookup table, the 512-word cursor bitmap, a three-entry cursor color set, or a handful of scalar registers. The scalar registers are the control word, the frame base address, the visible width and height, and the cursor location.

The two large tables live outside the block. Writes to them are passed on combinationally through a table port. Cursor bitmap reads use the same port with a synchronous one-cycle read. The block keeps the cursor colors and the scalar registers itself. It converts width and height between their scaled register encodings, and it decodes the control word into pixel depth, forced blanking and cursor enable for the video pipeline.

A write to the soft reset address returns all programmable state to zero. The frame interrupt is raised by an end-of-frame pulse and dropped by any register write.

Top module: `fbctl_regdec`

## Requirements
- R1: A write to a byte address in 0x800..0xFFF asserts `tbl_we` in the same cycle with `tbl_sel`=0, `tbl_idx`=(addr-0x800)>>3 and `tbl_wdata`=data[23:0] (red 23:16, green 15:8, blue 7:0). Reads in that range return zero.
- R2: A write to a byte address in 0x1000..0x1FFF asserts `tbl_we` in the same cycle with `tbl_sel`=1, `tbl_idx`=(addr-0x1000)>>3 and `tbl_wdata[15:0]`=data[15:0].
- R3: Read data appears on `bus_rdata` in the cycle after the read strobe. A read of the cursor bitmap range raises `tbl_re` with the entry index in the strobe cycle, and returns the 16-bit `tbl_rdata` zero-extended.
- R4: The cursor colors sit at 0x508, 0x510 and 0x518, on an 8-byte stride that ends before 0x520. Each holds data[23:0] with the same color packing. A read returns that value, and entry k drives `cursor_colors[24k+23:24k]`.
- R5: A write of v to 0x118 sets `width_px` to (v*4) mod 2^12. A read of 0x118 returns `width_px`/4.
- R6: A write of v to 0x150 sets `height_px` to v/2 (truncated to 12 bits). A read of 0x150 returns `height_px`*2, so odd values come back even.
- R7: The control word at 0x300 reads back as written. Bits 22:20 give `depth_bpp` through codes 0..7 -> 1, 2, 4, 8, 15, 16, 0, 0. Bit 10 drives `force_blank` and bit 23 drives `cursor_off`.
- R8: A write to 0x400 sets `top_addr`. A write to 0x638 sets `cursor_x`=data[23:12] and `cursor_y`=data[11:0]. Reads of both addresses return zero.
- R9: Writes to the timing addresses 0x000, 0x108, 0x110, 0x120..0x148 (stride 8), 0x158..0x170 (stride 8) and 0x200, and to unmapped addresses, change no register. Reads of unmapped addresses return zero.
- R10: A write to 0x100000 clears the control word, frame base, width, height, cursor location and cursor colors. In the same cycle it pulses `tbl_clr` so the external tables are cleared.
- R11: `irq` rises the cycle after a `frame_done` pulse. Any write clears it the next cycle. A write and `frame_done` in the same cycle leave `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 21 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| frame_done | input | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Frame interrupt |
| tbl_we | output | 1 | Table write enable |
| tbl_re | output | 1 | Cursor bitmap read enable |
| tbl_sel | output | 1 | 0 color table, 1 cursor bitmap |
| tbl_idx | output | 9 | Table entry index |
| tbl_wdata | output | 24 | Table write data |
| tbl_rdata | input | 16 | Cursor bitmap data, one cycle after `tbl_re` |
| tbl_clr | output | 1 | Clear both tables |
| width_px | output | 12 | Visible width in pixels |
| height_px | output | 12 | Visible height in lines |
| depth_bpp | output | 5 | Decoded bits per pixel |
| force_blank | output | 1 | Force display blank |
| cursor_off | output | 1 | Cursor disabled |
| top_addr | output | 32 | Frame base address |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| cursor_colors | output | 72 | Three packed cursor colors |

## Verification
The bench targets the range edges: the first and last color entries, the last bitmap word at 0x1FF8, the third cursor color at 0x51C, and 0x520 just past it. An off-by-one decoder would send those writes to the wrong target or read back zero. Odd height writes and width values wider than the field are used to expose a missing halving or a missing truncation. Every depth code, including both zero codes, is exercised. Each timing address is written and all state is then read back, so a decoder that lets an ignored address alias onto a real register shows a changed value. The write and `frame_done` collision is driven so that a set-wins interrupt is caught.

// File: rtl/fbctl_pkg.sv
// Shared address map, target encoding and depth decode for the register decoder.
package fbctl_pkg;
    typedef enum logic [3:0] {
        T_NONE, T_IGN, T_COLOR, T_PAT, T_CPAL,
        T_HDISP, T_VDISP, T_CTRL, T_TOP, T_CPOS, T_SRST
    } tgt_e;

    localparam logic [31:0] A_HDISP    = 32'h0000_0118;
    localparam logic [31:0] A_VDISP    = 32'h0000_0150;
    localparam logic [31:0] A_CTRL     = 32'h0000_0300;
    localparam logic [31:0] A_TOP      = 32'h0000_0400;
    localparam logic [31:0] A_CPOS     = 32'h0000_0638;
    localparam logic [31:0] A_SRST     = 32'h0010_0000;
    localparam logic [31:0] A_CPAL     = 32'h0000_0508;
    localparam logic [31:0] A_CPAL_END = 32'h0000_0520;
    localparam logic [31:0] A_COLOR    = 32'h0000_0800;
    localparam logic [31:0] A_PAT      = 32'h0000_1000;
    localparam logic [31:0] A_PAT_END  = 32'h0000_2000;

    // Map the 3-bit depth code of the control word to bits per pixel.
    function automatic logic [4:0] depth_of(input logic [2:0] code);
        case (code)
            3'd0: depth_of = 5'd1;
            3'd1: depth_of = 5'd2;
            3'd2: depth_of = 5'd4;
            3'd3: depth_of = 5'd8;
            3'd4: depth_of = 5'd15;
            3'd5: depth_of = 5'd16;
            default: depth_of = 5'd0;
        endcase
    endfunction
endpackage

// File: rtl/fbctl_decode.sv
// Address decoder: classifies a byte address into a target and table index.
// Assumes ADDR_W <= 32; purely combinational.
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic [ADDR_W-1:0] addr_i,
    output tgt_e              tgt_o,
    output logic [8:0]        idx_o,
    output logic [1:0]        cidx_o
);
    logic [31:0] a;
    logic [31:0] coff;

    assign a      = 32'(addr_i);
    assign coff   = a - A_CPAL;
    assign cidx_o = coff[4:3];

    // Range checks first, then exact scalar and ignored addresses.
    always_comb begin
        tgt_o = T_NONE;
        idx_o = a[11:3];
        if (a >= A_COLOR && a < A_PAT) begin
            tgt_o = T_COLOR;
            idx_o = {1'b0, a[10:3]};
        end else if (a >= A_PAT && a < A_PAT_END) begin
            tgt_o = T_PAT;
        end else if (a >= A_CPAL && a < A_CPAL_END) begin
            tgt_o = T_CPAL;
        end else begin
            case (a)
                A_HDISP: tgt_o = T_HDISP;
                A_VDISP: tgt_o = T_VDISP;
                A_CTRL:  tgt_o = T_CTRL;
                A_TOP:   tgt_o = T_TOP;
                A_CPOS:  tgt_o = T_CPOS;
                A_SRST:  tgt_o = T_SRST;
                32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130,
                32'h138, 32'h140, 32'h148, 32'h158, 32'h160, 32'h168,
                32'h170, 32'h200: tgt_o = T_IGN;
                default: tgt_o = T_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fbctl_scalar.sv
// Scalar register file: control word, frame base, dimensions, cursor location
// and cursor colors, with soft reset and a combinational read mux.
// Assumes DIM_W >= 3; width is stored pre-scaled by 4, height by 1/2.
module fbctl_scalar
    import fbctl_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int POS_W = 12,
    parameter int TOP_W = 32,
    parameter int NCUR  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  tgt_e                  tgt_i,
    input  logic [1:0]            cidx_i,
    input  logic [31:0]           wdata_i,
    output logic [31:0]           rd_o,
    output logic [DIM_W-1:0]      width_o,
    output logic [DIM_W-1:0]      height_o,
    output logic [31:0]           ctrl_o,
    output logic [TOP_W-1:0]      top_o,
    output logic [2*POS_W-1:0]    cpos_o,
    output logic [NCUR*24-1:0]    ccol_o
);
    localparam int CPOS_W = 2 * POS_W;

    logic [23:0] cpal_q [NCUR];
    logic        soft_rst;

    assign soft_rst = wr_i && (tgt_i == T_SRST);

    // Scalar register updates with hard and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            width_o  <= '0;
            height_o <= '0;
            ctrl_o   <= '0;
            top_o    <= '0;
            cpos_o   <= '0;
        end else if (wr_i) begin
            case (tgt_i)
                T_HDISP: width_o  <= {wdata_i[DIM_W-3:0], 2'b00};
                T_VDISP: height_o <= wdata_i[DIM_W:1];
                T_CTRL:  ctrl_o   <= wdata_i;
                T_TOP:   top_o    <= wdata_i[TOP_W-1:0];
                T_CPOS:  cpos_o   <= wdata_i[CPOS_W-1:0];
                default: ;
            endcase
        end
    end

    // One cursor color register per entry.
    for (genvar k = 0; k < NCUR; k++) begin : g_cpal
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                cpal_q[k] <= '0;
            else if (wr_i && tgt_i == T_CPAL && cidx_i == 2'(k))
                cpal_q[k] <= wdata_i[23:0];
        end
        assign ccol_o[k*24 +: 24] = cpal_q[k];
    end

    // Read value for the readable scalar targets; zero elsewhere.
    always_comb begin
        case (tgt_i)
            T_CPAL:  rd_o = (cidx_i < 2'(NCUR)) ? {8'h00, cpal_q[cidx_i]} : '0;
            T_HDISP: rd_o = 32'(width_o >> 2);
            T_VDISP: rd_o = 32'({height_o, 1'b0});
            T_CTRL:  rd_o = ctrl_o;
            default: rd_o = '0;
        endcase
    end

    // R6: a vertical write stores half the written value.
    a_r6_height_half: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && tgt_i == T_VDISP) |=> height_o == $past(wdata_i[DIM_W:1]));

    // R10: soft reset clears the scalar state.
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_o == '0 && width_o == '0 && height_o == '0 &&
                      top_o == '0 && cpos_o == '0));

    // R9: ignored timing writes leave the scalar state unchanged.
    a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && tgt_i == T_IGN) |=> (ctrl_o == $past(ctrl_o) &&
                                       width_o == $past(width_o) &&
                                       height_o == $past(height_o)));
endmodule

// File: rtl/fbctl_irq.sv
// Frame interrupt flag: set by an end-of-frame pulse, cleared by any write;
// a write in the same cycle wins over the set.
module fbctl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic frame_done_i,
    output logic irq_o
);
    // Interrupt flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)            irq_o <= 1'b0;
        else if (wr_i)         irq_o <= 1'b0;
        else if (frame_done_i) irq_o <= 1'b1;
    end

    // R11: any write drops the interrupt.
    a_r11_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !irq_o);

    // R11: a frame pulse without a write raises it.
    a_r11_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !wr_i) |=> irq_o);
endmodule

// File: rtl/fbctl_regdec.sv
// Top of the framebuffer register decoder: routes table writes to the
// external table port, holds scalar state, registers read data one cycle
// after the strobe and drives the frame interrupt.
// Assumes the external cursor bitmap store answers tbl_re one cycle later.
module fbctl_regdec
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DIM_W  = 12,
    parameter int POS_W  = 12,
    parameter int TOP_W  = 32,
    parameter int NCUR   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 frame_done,
    output logic                 irq,
    output logic                 tbl_we,
    output logic                 tbl_re,
    output logic                 tbl_sel,
    output logic [8:0]           tbl_idx,
    output logic [23:0]          tbl_wdata,
    input  logic [15:0]          tbl_rdata,
    output logic                 tbl_clr,
    output logic [DIM_W-1:0]     width_px,
    output logic [DIM_W-1:0]     height_px,
    output logic [4:0]           depth_bpp,
    output logic                 force_blank,
    output logic                 cursor_off,
    output logic [TOP_W-1:0]     top_addr,
    output logic [POS_W-1:0]     cursor_x,
    output logic [POS_W-1:0]     cursor_y,
    output logic [NCUR*24-1:0]   cursor_colors
);
    tgt_e                tgt;
    logic [1:0]          cidx;
    logic [31:0]         scalar_rd;
    logic [31:0]         ctrl;
    logic [2*POS_W-1:0]  cpos;
    logic [31:0]         rdata_q;
    logic                pat_rd_q;

    fbctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr),
        .tgt_o  (tgt),
        .idx_o  (tbl_idx),
        .cidx_o (cidx)
    );

    fbctl_scalar #(.DIM_W(DIM_W), .POS_W(POS_W), .TOP_W(TOP_W), .NCUR(NCUR)) u_scalar (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .tgt_i    (tgt),
        .cidx_i   (cidx),
        .wdata_i  (bus_wdata),
        .rd_o     (scalar_rd),
        .width_o  (width_px),
        .height_o (height_px),
        .ctrl_o   (ctrl),
        .top_o    (top_addr),
        .cpos_o   (cpos),
        .ccol_o   (cursor_colors)
    );

    fbctl_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (bus_wr),
        .frame_done_i (frame_done),
        .irq_o        (irq)
    );

    // Table port: forward writes, request bitmap reads, clear on soft reset.
    assign tbl_sel   = (tgt == T_PAT);
    assign tbl_we    = bus_wr && (tgt == T_COLOR || tgt == T_PAT);
    assign tbl_re    = bus_rd && (tgt == T_PAT);
    assign tbl_wdata = (tgt == T_PAT) ? {8'h00, bus_wdata[15:0]} : bus_wdata[23:0];
    assign tbl_clr   = bus_wr && (tgt == T_SRST);

    // Control word decode for the video pipeline.
    assign depth_bpp   = depth_of(ctrl[22:20]);
    assign force_blank = ctrl[10];
    assign cursor_off  = ctrl[23];
    assign cursor_x    = cpos[2*POS_W-1:POS_W];
    assign cursor_y    = cpos[POS_W-1:0];

    // Read data register, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            pat_rd_q <= 1'b0;
        end else begin
            rdata_q  <= bus_rd ? scalar_rd : '0;
            pat_rd_q <= tbl_re;
        end
    end

    assign bus_rdata = pat_rd_q ? {16'h0000, tbl_rdata} : rdata_q;

    // R3: the cycle after a bitmap read, the upper half of the read data is zero.
    a_r3_pat_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_re |=> bus_rdata[31:16] == 16'h0000);

    // R7: the decoded depth is always one of the table values.
    a_r7_depth_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_bpp == 5'd0 || depth_bpp == 5'd1 || depth_bpp == 5'd2 ||
         depth_bpp == 5'd4 || depth_bpp == 5'd8 || depth_bpp == 5'd15 ||
         depth_bpp == 5'd16));

    // R1: table writes only ever come from a bus write.
    a_r1_tbl_we_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> bus_wr);
endmodule

// File: tb/test_fbctl_regdec.sv
`timescale 1ns/1ps
module test_fbctl_regdec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, frame_done = 1'b0;
    logic [20:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tbl_we, tbl_re, tbl_sel, tbl_clr;
    logic [8:0]  tbl_idx;
    logic [23:0] tbl_wdata;
    logic [15:0] tbl_rdata;
    logic [11:0] width_px, height_px, cursor_x, cursor_y;
    logic [4:0]  depth_bpp;
    logic        force_blank, cursor_off;
    logic [31:0] top_addr;
    logic [71:0] cursor_colors;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    fbctl_regdec i_fbctl_regdec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_done(frame_done), .irq(irq), .tbl_we(tbl_we), .tbl_re(tbl_re),
        .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .tbl_rdata(tbl_rdata), .tbl_clr(tbl_clr), .width_px(width_px),
        .height_px(height_px), .depth_bpp(depth_bpp), .force_blank(force_blank),
        .cursor_off(cursor_off), .top_addr(top_addr), .cursor_x(cursor_x),
        .cursor_y(cursor_y), .cursor_colors(cursor_colors)
    );

    // External cursor bitmap store model: synchronous read, cleared on tbl_clr.
    logic [15:0] pat_mem [512];
    logic [15:0] ram_q = '0;
    assign tbl_rdata = ram_q;
    always @(posedge clk) begin
        if (tbl_clr) begin
            for (int i = 0; i < 512; i++) pat_mem[i] <= '0;
        end else if (tbl_we && tbl_sel) begin
            pat_mem[tbl_idx] <= tbl_wdata[15:0];
        end
        if (tbl_re) ram_q <= pat_mem[tbl_idx];
    end

    // Captured table-port values from the last access.
    logic        c_we, c_sel, c_clr, c_re;
    logic [8:0]  c_idx;
    logic [23:0] c_wd;

    // Bench model of the scalar state.
    logic [11:0] m_width, m_height, m_cx, m_cy;
    logic [31:0] m_ctrl, m_top;
    logic [23:0] m_cpal [3];

    function automatic logic [4:0] exp_depth(input logic [2:0] c);
        logic [4:0] t [8];
        t = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd0, 5'd0};
        return t[c];
    endfunction

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a[20:0]; bus_wdata = d; bus_wr = 1'b1;
        #1;
        c_we = tbl_we; c_sel = tbl_sel; c_idx = tbl_idx; c_wd = tbl_wdata; c_clr = tbl_clr;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a[20:0]; bus_rd = 1'b1;
        #1;
        c_re = tbl_re; c_idx = tbl_idx;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic model_reset();
        m_width = '0; m_height = '0; m_cx = '0; m_cy = '0; m_ctrl = '0; m_top = '0;
        for (int k = 0; k < 3; k++) m_cpal[k] = '0;
    endtask

    // Compare every scalar output and readback with the model.
    task automatic check_all(input string req);
        logic [31:0] v;
        chk(req, width_px, m_width);
        chk(req, height_px, m_height);
        chk(req, depth_bpp, exp_depth(m_ctrl[22:20]));
        chk(req, {force_blank, cursor_off}, {m_ctrl[10], m_ctrl[23]});
        chk(req, top_addr, m_top);
        chk(req, {cursor_x, cursor_y}, {m_cx, m_cy});
        chk(req, cursor_colors, {m_cpal[2], m_cpal[1], m_cpal[0]});
        rd(32'h118, v); chk(req, v, 32'(m_width >> 2));
        rd(32'h150, v); chk(req, v, 32'({m_height, 1'b0}));
        rd(32'h300, v); chk(req, v, m_ctrl);
        for (int k = 0; k < 3; k++) begin
            rd(32'h508 + 32'(8 * k), v); chk(req, v, {8'h00, m_cpal[k]});
        end
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, d, r;
        r = $urandom(32'd20240601);
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state (R7 depth code 0 decodes to 1 bpp, R11 irq low).
        chk("R11 reset irq", irq, 1'b0);
        chk("R3 reset rdata", bus_rdata, 32'h0);
        check_all("R7 reset state");

        // R1: color table writes at both ends, reads return zero.
        wr(32'h800, 32'hAB12_3456);
        chk("R1 we/sel/idx", {c_we, c_sel, c_idx}, {1'b1, 1'b0, 9'd0});
        chk("R1 wdata", c_wd, 24'h12_3456);
        wr(32'hFFC, 32'h00FE_DCBA);
        chk("R1 last entry", {c_we, c_sel, c_idx, c_wd}, {1'b1, 1'b0, 9'd255, 24'hFE_DCBA});
        rd(32'h828, v); chk("R1 color read zero", v, 32'h0);

        // R2/R3: cursor bitmap edges and zero-extended readback.
        wr(32'h1000, 32'hFFFF_1234);
        chk("R2 first word", {c_we, c_sel, c_idx, c_wd[15:0]}, {1'b1, 1'b1, 9'd0, 16'h1234});
        wr(32'h1FF8, 32'h0000_BEEF);
        chk("R2 last word", {c_we, c_sel, c_idx, c_wd[15:0]}, {1'b1, 1'b1, 9'd511, 16'hBEEF});
        rd(32'h1FF8, v);
        chk("R3 tbl_re idx", {c_re, c_idx}, {1'b1, 9'd511});
        chk("R3 bitmap read", v, 32'h0000_BEEF);
        rd(32'h1000, v); chk("R3 bitmap read first", v, 32'h0000_1234);

        // R4: cursor colors, third via a non-aligned offset, 0x520 unmapped.
        wr(32'h508, 32'hFF11_2233); m_cpal[0] = 24'h11_2233;
        wr(32'h510, 32'h0044_5566); m_cpal[1] = 24'h44_5566;
        wr(32'h51C, 32'h0077_8899); m_cpal[2] = 24'h77_8899;
        chk("R4 no table write", c_we, 1'b0);
        wr(32'h520, 32'h00AA_AAAA);
        rd(32'h520, v); chk("R9 past cursor colors", v, 32'h0);
        check_all("R4 cursor colors");

        // R5/R6: directed odd height and oversize width.
        wr(32'h150, 32'd601); m_height = 12'd300;
        wr(32'h118, 32'hFFFF_F7FF); m_width = 12'hFFC;
        check_all("R5 R6 directed dims");

        // R7: every depth code.
        for (int c = 0; c < 8; c++) begin
            d = 32'(c) << 20;
            wr(32'h300, d); m_ctrl = d;
            chk("R7 depth code", depth_bpp, exp_depth(3'(c)));
        end

        // R8: frame base and cursor location, reads return zero.
        wr(32'h400, 32'h0012_3400); m_top = 32'h0012_3400;
        wr(32'h638, 32'hFFAB_C123); m_cx = 12'hABC; m_cy = 12'h123;
        rd(32'h400, v); chk("R8 top read zero", v, 32'h0);
        rd(32'h638, v); chk("R8 pos read zero", v, 32'h0);
        check_all("R8 top and cursor");

        // Random mix of scalar and bitmap traffic against the model.
        for (int it = 0; it < 300; it++) begin
            int op;
            d  = $urandom;
            op = $urandom_range(0, 5);
            case (op)
                0: begin wr(32'h118, d); m_width = {d[9:0], 2'b00}; end
                1: begin wr(32'h150, d); m_height = d[12:1]; end
                2: begin wr(32'h300, d); m_ctrl = d; end
                3: begin
                    int k = $urandom_range(0, 2);
                    wr(32'h508 + 32'(8 * k) + 32'($urandom_range(0, 1) * 4), d);
                    m_cpal[k] = d[23:0];
                end
                4: begin wr(32'h638, d); m_cx = d[23:12]; m_cy = d[11:0]; end
                default: begin
                    logic [8:0] ix = 9'($urandom);
                    wr(32'h1000 + 32'(ix) * 8, d);
                    rd(32'h1000 + 32'(ix) * 8, v);
                    chk("R3 random bitmap", v, {16'h0, d[15:0]});
                end
            endcase
            if (it % 25 == 0) check_all("R5 R6 R7 R4 random");
        end
        check_all("R5 R6 R7 R4 random end");

        // R9: ignored timing writes and unmapped accesses change nothing.
        begin
            logic [31:0] ign [14];
            ign = '{32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
                    32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200};
            for (int k = 0; k < 14; k++) begin
                wr(ign[k], $urandom);
                chk("R9 ignored no table write", c_we, 1'b0);
            end
            wr(32'h0F_0000, 32'hFFFF_FFFF);
            rd(32'h0F_0000, v); chk("R9 unmapped read", v, 32'h0);
            rd(32'h108, v); chk("R9 timing read", v, 32'h0);
            check_all("R9 state unchanged");
        end

        // R11: interrupt set, cleared by write, write wins on collision.
        frame_done = 1'b1; @(posedge clk); #1 frame_done = 1'b0;
        chk("R11 frame sets irq", irq, 1'b1);
        @(posedge clk); #1;
        chk("R11 irq holds", irq, 1'b1);
        wr(32'h148, 32'h1);
        chk("R11 ignored write clears irq", irq, 1'b0);
        frame_done = 1'b1; @(posedge clk); #1 frame_done = 1'b0;
        frame_done = 1'b1;
        wr(32'h400, 32'h55);  m_top = 32'h55;
        frame_done = 1'b0;
        chk("R11 write wins", irq, 1'b0);

        // R10: soft reset clears state and the external tables.
        frame_done = 1'b1; @(posedge clk); #1 frame_done = 1'b0;
        wr(32'h10_0000, 32'h0);
        chk("R10 tbl_clr pulse", c_clr, 1'b1);
        chk("R10 irq lowered", irq, 1'b0);
        model_reset();
        check_all("R10 soft reset");
        rd(32'h1FF8, v); chk("R10 bitmap cleared", v, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule